// File: doc/BRIEF.md
# Forth Stack and Memory-Access Slice

This block is the memory-group slice of a 16-bit Harvard processor built to run threaded Forth code. Each cycle it takes the five-bit memory-group field from the top of the current opcode. From that field it updates six registers: the data-memory address register MA, the load register LX, the threaded-code pointer IP, the frame pointer LF, and two 5-bit stack pointers, RS for the return stack and SS for the single-cell data stack. It also picks the next program counter value.

The two stack pointers never hold a full address. The return stack lives in the top 32 words of page zero and the data stack lives in the 32 words below it. The slice forms each address by joining the window base with the pointer. LF points into the return-stack window in the same way.

Every load and store in the slice uses MA as its address. Load data arrives on the read port in the same cycle and is captured at the clock edge. The slice reads AX, BX, DX and the carry flag from its neighbour slices but never writes them. The POLL, NEXT and FULL entry points are fixed by parameters.

Top module: `fstk_mem_slice`

## Requirements
- R1: When opcode bits 15:11 are 0 (no operation), MA, LX, IP, LF, RS and SS all keep their values, dm_we stays low, and PC advances by 1. Opcode bits 10:0 have no effect on this slice for any code.
- R2: While rst is high and in the first cycle after it, PC reads RESET_PC (default 0). MA, LX, IP, LF, RS and SS all read 0, and dm_we is low.
- R3: Code 28 (return push) sets RS to RS-1 and MA to $00E0 + (RS-1). Code 29 (return pull) sets MA to $00E0 + RS and then sets RS to RS+1. Both wrap modulo 32.
- R4: Code 30 (data push) sets SS to SS-1 and MA to $00C0 + (SS-1). Code 31 (data pull) sets MA to $00C0 + SS and SS to SS+1. Code 26 sets MA to $00C0 + SS. Code 27 sets MA to $00C0 + ((SS+1) mod 32).
- R5: Code 17 (next) writes IP+1 into both IP and MA and loads NEXT_VEC into PC.
- R6: Code 19 (primitive jump) loads LX[14:0] into PC when LX[15] is 1. Otherwise PC advances by 1.
- R7: Code 20 (enter) does three things in one cycle: it writes the old IP to data memory at the old MA, loads LX into both IP and MA, and loads NEXT_VEC into PC.
- R8: Code 14 adds LX to IP only when cf_i is 1, and leaves IP unchanged otherwise. Code 15 adds 1 to IP. Code 2 sets LX to $FFFF. Code 1 copies AX into LX.
- R9: Code 24 sets MA to $00E0 + LF. Code 25 sets MA to $00E0 + LF + AX (16-bit sum). Code 10 copies RS into LF. Code 11 copies LF into RS. Code 12 sets RS to (RS + AX[4:0]) mod 32.
- R10: Codes 3, 4 and 5 load dm_rdata from address MA into LX, IP or LF respectively (LF takes bits 4:0), with dm_re high. Codes 6, 7, 8 and 9 raise dm_we and drive IP, AX, BX or LX onto dm_wdata at address MA. dm_we is low for every code other than 6 to 9 and 20.
- R11: Code 16 loads POLL_VEC into PC. Code 18 loads FULL_VEC into PC when cf_i is 1, and otherwise advances PC by 1.
- R12: Code 13 copies IP into MA. Codes 21, 22 and 23 copy AX, BX and DX into MA.
- R13: Every operand is the value held before the clock edge. A pull places the old pointer in MA. The enter operation stores the old IP even though it rewrites IP in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 16 | Current opcode; bits 15:11 drive this slice |
| ax_i | input | 16 | AX from the arithmetic slice |
| bx_i | input | 16 | BX (top of data stack) from the flag slice |
| dx_i | input | 16 | DX from the flag slice |
| cf_i | input | 1 | Carry flag |
| dm_rdata | input | 16 | Data-memory read data for address dm_addr |
| dm_addr | output | 16 | Data-memory word address (MA) |
| dm_we | output | 1 | Data-memory write strobe |
| dm_wdata | output | 16 | Data-memory write data |
| dm_re | output | 1 | Data-memory read strobe |
| pc_o | output | 15 | Program counter |
| ma_o | output | 16 | MA register |
| lx_o | output | 16 | LX register |
| ip_o | output | 16 | IP register |
| lf_o | output | 5 | Frame pointer offset in the return window |
| rs_o | output | 5 | Return-stack pointer |
| ss_o | output | 5 | Data-stack pointer |

## Verification
The bound checker watches every cycle for several things. It checks that a no-operation field leaves the state quiet. It checks the pointer and MA results of return and data pushes and pulls, and the NEXT dispatch. It checks the taken primitive jump, the write-and-enter cycle, and the carry-gated IP add and FULL jump. It also checks that only store codes raise the write strobe. The bench scenarios are needed for the rest. These are the reset values, loads whose data comes back through memory written earlier in the same run, pointer wrap at both window edges, and the frame and local address arithmetic. They also cover the not-taken cases with the high LX bit clear and the carry clear, and the fact that opcode bits 10:0 are ignored.

// File: rtl/fstk_pkg.sv
package fstk_pkg;

    localparam int DW  = 16;            // data and address width
    localparam int PW  = 5;             // stack pointer width
    localparam int PCW = 15;            // code address width
    localparam int FW  = 5;             // memory-group field width
    localparam int FLO = DW - FW;       // low bit of the field

    typedef enum logic [FW-1:0] {
        OP_NOP      = 5'd0,
        OP_LX_AX    = 5'd1,
        OP_LX_ONES  = 5'd2,
        OP_LD_LX    = 5'd3,
        OP_LD_IP    = 5'd4,
        OP_LD_LF    = 5'd5,
        OP_ST_IP    = 5'd6,
        OP_ST_AX    = 5'd7,
        OP_ST_BX    = 5'd8,
        OP_ST_LX    = 5'd9,
        OP_LF_GETRS = 5'd10,
        OP_RS_GETLF = 5'd11,
        OP_RS_ADD   = 5'd12,
        OP_MA_IP    = 5'd13,
        OP_IP_CADD  = 5'd14,
        OP_IP_INC   = 5'd15,
        OP_POLL     = 5'd16,
        OP_NEXT     = 5'd17,
        OP_TRAP     = 5'd18,
        OP_PJMP     = 5'd19,
        OP_ENTER    = 5'd20,
        OP_MA_AX    = 5'd21,
        OP_MA_BX    = 5'd22,
        OP_MA_DX    = 5'd23,
        OP_MA_FRAME = 5'd24,
        OP_MA_LOCAL = 5'd25,
        OP_MA_S0    = 5'd26,
        OP_MA_S1    = 5'd27,
        OP_RPUSH    = 5'd28,
        OP_RPULL    = 5'd29,
        OP_SPUSH    = 5'd30,
        OP_SPULL    = 5'd31
    } mop_e;

    typedef enum logic [3:0] {
        MA_HOLD, MA_FROM_IP, MA_FROM_IPINC, MA_FROM_LX, MA_FROM_AX,
        MA_FROM_BX, MA_FROM_DX, MA_FRAME, MA_LOCAL, MA_SS_CUR,
        MA_SS_INC, MA_SS_DEC, MA_RS_CUR, MA_RS_DEC
    } ma_sel_e;

    typedef enum logic [1:0] { LX_HOLD, LX_FROM_AX, LX_ALL_ONES, LX_FROM_MEM } lx_sel_e;
    typedef enum logic [2:0] { IP_HOLD, IP_FROM_MEM, IP_PLUS1, IP_COND_ADD, IP_FROM_LX } ip_sel_e;
    typedef enum logic [1:0] { LF_HOLD, LF_FROM_MEM, LF_FROM_RS } lf_sel_e;
    typedef enum logic [2:0] { SP_HOLD, SP_INC, SP_DEC, SP_ADD, SP_LOAD } sp_op_e;
    typedef enum logic [2:0] { PC_STEP, PC_POLL, PC_NEXT, PC_TRAP, PC_PRIM } pc_sel_e;
    typedef enum logic [2:0] { ST_NONE, ST_IP, ST_AX, ST_BX, ST_LX } st_sel_e;

    typedef struct packed {
        ma_sel_e ma_sel;
        lx_sel_e lx_sel;
        ip_sel_e ip_sel;
        lf_sel_e lf_sel;
        sp_op_e  rs_op;
        sp_op_e  ss_op;
        pc_sel_e pc_sel;
        st_sel_e st_sel;
        logic    rd;
    } mctl_t;

    // join a window base with a pointer offset
    function automatic logic [DW-1:0] win_addr(input logic [DW-1:0] base,
                                               input logic [PW-1:0] ofs);
        return base | {{(DW-PW){1'b0}}, ofs};
    endfunction

endpackage

// File: rtl/fstk_decode.sv
module fstk_decode
    import fstk_pkg::*;
(
    input  mop_e  op,
    output mctl_t ctl
);
    always_comb begin
        ctl = '{ma_sel: MA_HOLD, lx_sel: LX_HOLD, ip_sel: IP_HOLD, lf_sel: LF_HOLD,
                rs_op: SP_HOLD, ss_op: SP_HOLD, pc_sel: PC_STEP, st_sel: ST_NONE,
                rd: 1'b0};
        unique case (op)
            OP_NOP:      ;
            OP_LX_AX:    ctl.lx_sel = LX_FROM_AX;
            OP_LX_ONES:  ctl.lx_sel = LX_ALL_ONES;
            OP_LD_LX:    begin ctl.lx_sel = LX_FROM_MEM; ctl.rd = 1'b1; end
            OP_LD_IP:    begin ctl.ip_sel = IP_FROM_MEM; ctl.rd = 1'b1; end
            OP_LD_LF:    begin ctl.lf_sel = LF_FROM_MEM; ctl.rd = 1'b1; end
            OP_ST_IP:    ctl.st_sel = ST_IP;
            OP_ST_AX:    ctl.st_sel = ST_AX;
            OP_ST_BX:    ctl.st_sel = ST_BX;
            OP_ST_LX:    ctl.st_sel = ST_LX;
            OP_LF_GETRS: ctl.lf_sel = LF_FROM_RS;
            OP_RS_GETLF: ctl.rs_op = SP_LOAD;
            OP_RS_ADD:   ctl.rs_op = SP_ADD;
            OP_MA_IP:    ctl.ma_sel = MA_FROM_IP;
            OP_IP_CADD:  ctl.ip_sel = IP_COND_ADD;
            OP_IP_INC:   ctl.ip_sel = IP_PLUS1;
            OP_POLL:     ctl.pc_sel = PC_POLL;
            OP_NEXT:     begin
                ctl.ip_sel = IP_PLUS1;
                ctl.ma_sel = MA_FROM_IPINC;
                ctl.pc_sel = PC_NEXT;
            end
            OP_TRAP:     ctl.pc_sel = PC_TRAP;
            OP_PJMP:     ctl.pc_sel = PC_PRIM;
            OP_ENTER:    begin
                ctl.st_sel = ST_IP;
                ctl.ip_sel = IP_FROM_LX;
                ctl.ma_sel = MA_FROM_LX;
                ctl.pc_sel = PC_NEXT;
            end
            OP_MA_AX:    ctl.ma_sel = MA_FROM_AX;
            OP_MA_BX:    ctl.ma_sel = MA_FROM_BX;
            OP_MA_DX:    ctl.ma_sel = MA_FROM_DX;
            OP_MA_FRAME: ctl.ma_sel = MA_FRAME;
            OP_MA_LOCAL: ctl.ma_sel = MA_LOCAL;
            OP_MA_S0:    ctl.ma_sel = MA_SS_CUR;
            OP_MA_S1:    ctl.ma_sel = MA_SS_INC;
            OP_RPUSH:    begin ctl.rs_op = SP_DEC; ctl.ma_sel = MA_RS_DEC; end
            OP_RPULL:    begin ctl.rs_op = SP_INC; ctl.ma_sel = MA_RS_CUR; end
            OP_SPUSH:    begin ctl.ss_op = SP_DEC; ctl.ma_sel = MA_SS_DEC; end
            OP_SPULL:    begin ctl.ss_op = SP_INC; ctl.ma_sel = MA_SS_CUR; end
            default:     ;
        endcase
    end
endmodule

// File: rtl/fstk_sptr.sv
module fstk_sptr
    import fstk_pkg::*;
#(
    parameter logic [DW-1:0] BASE = 16'h00E0
) (
    input  logic          clk,
    input  logic          rst,
    input  sp_op_e        op,
    input  logic [PW-1:0] val,
    output logic [PW-1:0] ptr,
    output logic [DW-1:0] addr_cur,
    output logic [DW-1:0] addr_dec,
    output logic [DW-1:0] addr_inc
);
    logic [PW-1:0] ptr_q, ptr_d, ptr_dec, ptr_inc;

    assign ptr_dec = ptr_q - PW'(1);
    assign ptr_inc = ptr_q + PW'(1);

    always_comb begin
        unique case (op)
            SP_INC:  ptr_d = ptr_inc;
            SP_DEC:  ptr_d = ptr_dec;
            SP_ADD:  ptr_d = ptr_q + val;
            SP_LOAD: ptr_d = val;
            default: ptr_d = ptr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

    assign ptr      = ptr_q;
    assign addr_cur = win_addr(BASE, ptr_q);
    assign addr_dec = win_addr(BASE, ptr_dec);
    assign addr_inc = win_addr(BASE, ptr_inc);
endmodule

// File: rtl/fstk_pcsel.sv
module fstk_pcsel
    import fstk_pkg::*;
#(
    parameter logic [PCW-1:0] POLL_VEC = 15'h0010,
    parameter logic [PCW-1:0] NEXT_VEC = 15'h0020,
    parameter logic [PCW-1:0] FULL_VEC = 15'h0030
) (
    input  pc_sel_e        sel,
    input  logic [PCW-1:0] pc,
    input  logic [DW-1:0]  lx,
    input  logic           cf,
    output logic [PCW-1:0] pc_nxt
);
    logic [PCW-1:0] pc_step;
    assign pc_step = pc + PCW'(1);

    always_comb begin
        unique case (sel)
            PC_POLL: pc_nxt = POLL_VEC;
            PC_NEXT: pc_nxt = NEXT_VEC;
            PC_TRAP: pc_nxt = cf ? FULL_VEC : pc_step;
            PC_PRIM: pc_nxt = lx[DW-1] ? lx[PCW-1:0] : pc_step;
            default: pc_nxt = pc_step;
        endcase
    end
endmodule

// File: rtl/fstk_mem_slice.sv
module fstk_mem_slice
    import fstk_pkg::*;
#(
    parameter logic [DW-1:0]  RS_BASE  = 16'h00E0,
    parameter logic [DW-1:0]  SS_BASE  = 16'h00C0,
    parameter logic [PCW-1:0] RESET_PC = 15'h0000,
    parameter logic [PCW-1:0] POLL_VEC = 15'h0010,
    parameter logic [PCW-1:0] NEXT_VEC = 15'h0020,
    parameter logic [PCW-1:0] FULL_VEC = 15'h0030
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [DW-1:0]  opcode,
    input  logic [DW-1:0]  ax_i,
    input  logic [DW-1:0]  bx_i,
    input  logic [DW-1:0]  dx_i,
    input  logic           cf_i,
    input  logic [DW-1:0]  dm_rdata,
    output logic [DW-1:0]  dm_addr,
    output logic           dm_we,
    output logic [DW-1:0]  dm_wdata,
    output logic           dm_re,
    output logic [PCW-1:0] pc_o,
    output logic [DW-1:0]  ma_o,
    output logic [DW-1:0]  lx_o,
    output logic [DW-1:0]  ip_o,
    output logic [PW-1:0]  lf_o,
    output logic [PW-1:0]  rs_o,
    output logic [PW-1:0]  ss_o
);
    mctl_t ctl;
    mop_e  op;
    assign op = mop_e'(opcode[DW-1:FLO]);

    logic [DW-1:0]  ma_q, ma_d, lx_q, lx_d, ip_q, ip_d;
    logic [PW-1:0]  lf_q, lf_d, rs_ptr, ss_ptr, rs_val;
    logic [PCW-1:0] pc_q, pc_d;
    logic [DW-1:0]  rs_cur, rs_dec, rs_inc, ss_cur, ss_dec, ss_inc, frame;

    fstk_decode u_dec (.op(op), .ctl(ctl));

    assign rs_val = (ctl.rs_op == SP_ADD) ? ax_i[PW-1:0] : lf_q;

    fstk_sptr #(.BASE(RS_BASE)) u_rs (
        .clk(clk), .rst(rst), .op(ctl.rs_op), .val(rs_val), .ptr(rs_ptr),
        .addr_cur(rs_cur), .addr_dec(rs_dec), .addr_inc(rs_inc)
    );

    fstk_sptr #(.BASE(SS_BASE)) u_ss (
        .clk(clk), .rst(rst), .op(ctl.ss_op), .val('0), .ptr(ss_ptr),
        .addr_cur(ss_cur), .addr_dec(ss_dec), .addr_inc(ss_inc)
    );

    fstk_pcsel #(.POLL_VEC(POLL_VEC), .NEXT_VEC(NEXT_VEC), .FULL_VEC(FULL_VEC)) u_pc (
        .sel(ctl.pc_sel), .pc(pc_q), .lx(lx_q), .cf(cf_i), .pc_nxt(pc_d)
    );

    assign frame = win_addr(RS_BASE, lf_q);

    always_comb begin
        unique case (ctl.ma_sel)
            MA_FROM_IP:    ma_d = ip_q;
            MA_FROM_IPINC: ma_d = ip_q + DW'(1);
            MA_FROM_LX:    ma_d = lx_q;
            MA_FROM_AX:    ma_d = ax_i;
            MA_FROM_BX:    ma_d = bx_i;
            MA_FROM_DX:    ma_d = dx_i;
            MA_FRAME:      ma_d = frame;
            MA_LOCAL:      ma_d = frame + ax_i;
            MA_SS_CUR:     ma_d = ss_cur;
            MA_SS_INC:     ma_d = ss_inc;
            MA_SS_DEC:     ma_d = ss_dec;
            MA_RS_CUR:     ma_d = rs_cur;
            MA_RS_DEC:     ma_d = rs_dec;
            default:       ma_d = ma_q;
        endcase
    end

    always_comb begin
        unique case (ctl.lx_sel)
            LX_FROM_AX:  lx_d = ax_i;
            LX_ALL_ONES: lx_d = '1;
            LX_FROM_MEM: lx_d = dm_rdata;
            default:     lx_d = lx_q;
        endcase
    end

    always_comb begin
        unique case (ctl.ip_sel)
            IP_FROM_MEM: ip_d = dm_rdata;
            IP_PLUS1:    ip_d = ip_q + DW'(1);
            IP_COND_ADD: ip_d = cf_i ? ip_q + lx_q : ip_q;
            IP_FROM_LX:  ip_d = lx_q;
            default:     ip_d = ip_q;
        endcase
    end

    always_comb begin
        unique case (ctl.lf_sel)
            LF_FROM_MEM: lf_d = dm_rdata[PW-1:0];
            LF_FROM_RS:  lf_d = rs_ptr;
            default:     lf_d = lf_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ma_q <= '0;
            lx_q <= '0;
            ip_q <= '0;
            lf_q <= '0;
            pc_q <= RESET_PC;
        end else begin
            ma_q <= ma_d;
            lx_q <= lx_d;
            ip_q <= ip_d;
            lf_q <= lf_d;
            pc_q <= pc_d;
        end
    end

    always_comb begin
        unique case (ctl.st_sel)
            ST_IP:   dm_wdata = ip_q;
            ST_AX:   dm_wdata = ax_i;
            ST_BX:   dm_wdata = bx_i;
            ST_LX:   dm_wdata = lx_q;
            default: dm_wdata = '0;
        endcase
    end

    assign dm_we   = (ctl.st_sel != ST_NONE) && !rst;
    assign dm_re   = ctl.rd && !rst;
    assign dm_addr = ma_q;
    assign pc_o    = pc_q;
    assign ma_o    = ma_q;
    assign lx_o    = lx_q;
    assign ip_o    = ip_q;
    assign lf_o    = lf_q;
    assign rs_o    = rs_ptr;
    assign ss_o    = ss_ptr;
endmodule

// File: rtl/fstk_mem_slice_chk.sv
module fstk_mem_slice_chk
    import fstk_pkg::*;
#(
    parameter logic [DW-1:0]  RS_BASE  = 16'h00E0,
    parameter logic [DW-1:0]  SS_BASE  = 16'h00C0,
    parameter logic [PCW-1:0] POLL_VEC = 15'h0010,
    parameter logic [PCW-1:0] NEXT_VEC = 15'h0020,
    parameter logic [PCW-1:0] FULL_VEC = 15'h0030
) (
    input logic           clk,
    input logic           rst,
    input logic [DW-1:0]  opcode,
    input logic           cf_i,
    input logic [DW-1:0]  dm_addr,
    input logic           dm_we,
    input logic [DW-1:0]  dm_wdata,
    input logic [PCW-1:0] pc_o,
    input logic [DW-1:0]  ma_o,
    input logic [DW-1:0]  lx_o,
    input logic [DW-1:0]  ip_o,
    input logic [PW-1:0]  lf_o,
    input logic [PW-1:0]  rs_o,
    input logic [PW-1:0]  ss_o
);
    mop_e fop;
    logic is_store;
    assign fop = mop_e'(opcode[DW-1:FLO]);
    assign is_store = (fop == OP_ST_IP) || (fop == OP_ST_AX) || (fop == OP_ST_BX) ||
                      (fop == OP_ST_LX) || (fop == OP_ENTER);

    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (fop == OP_NOP) |=> ($stable(ma_o) && $stable(lx_o) && $stable(ip_o) &&
                             $stable(lf_o) && $stable(rs_o) && $stable(ss_o) &&
                             pc_o == PCW'($past(pc_o) + PCW'(1)))); // R1

    AST_WE_ONLY_STORE: assert property (@(posedge clk) disable iff (rst)
        dm_we |-> is_store); // R10

    AST_RPUSH: assert property (@(posedge clk) disable iff (rst)
        (fop == OP_RPUSH) |=> (rs_o == PW'($past(rs_o) - PW'(1)) &&
                               ma_o == win_addr(RS_BASE, rs_o))); // R3

    AST_RPULL: assert property (@(posedge clk) disable iff (rst)
        (fop == OP_RPULL) |=> (rs_o == PW'($past(rs_o) + PW'(1)) &&
                               ma_o == win_addr(RS_BASE, $past(rs_o)))); // R3

    AST_SPUSH: assert property (@(posedge clk) disable iff (rst)
        (fop == OP_SPUSH) |=> (ss_o == PW'($past(ss_o) - PW'(1)) &&
                               ma_o == win_addr(SS_BASE, ss_o))); // R4

    AST_SPULL: assert property (@(posedge clk) disable iff (rst)
        (fop == OP_SPULL) |=> (ss_o == PW'($past(ss_o) + PW'(1)) &&
                               ma_o == win_addr(SS_BASE, $past(ss_o)))); // R4

    AST_NEXT: assert property (@(posedge clk) disable iff (rst)
        (fop == OP_NEXT) |=> (pc_o == NEXT_VEC && ip_o == DW'($past(ip_o) + DW'(1)) &&
                              ma_o == ip_o)); // R5

    AST_PJMP_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (fop == OP_PJMP && lx_o[DW-1]) |=> (pc_o == $past(lx_o[PCW-1:0]))); // R6

    AST_ENTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        (fop == OP_ENTER) |-> (dm_we && dm_wdata == ip_o && dm_addr == ma_o)); // R7

    AST_ENTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        (fop == OP_ENTER) |=> (ip_o == $past(lx_o) && ma_o == $past(lx_o) &&
                               pc_o == NEXT_VEC)); // R7

    AST_CADD_OFF: assert property (@(posedge clk) disable iff (rst)
        (fop == OP_IP_CADD && !cf_i) |=> $stable(ip_o)); // R8

    AST_CADD_ON: assert property (@(posedge clk) disable iff (rst)
        (fop == OP_IP_CADD && cf_i) |=> (ip_o == DW'($past(ip_o) + $past(lx_o)))); // R8

    AST_TRAP: assert property (@(posedge clk) disable iff (rst)
        (fop == OP_TRAP && cf_i) |=> (pc_o == FULL_VEC)); // R11

    AST_POLL: assert property (@(posedge clk) disable iff (rst)
        (fop == OP_POLL) |=> (pc_o == POLL_VEC)); // R11
endmodule

bind fstk_mem_slice fstk_mem_slice_chk #(
    .RS_BASE(RS_BASE), .SS_BASE(SS_BASE),
    .POLL_VEC(POLL_VEC), .NEXT_VEC(NEXT_VEC), .FULL_VEC(FULL_VEC)
) u_chk (
    .clk(clk), .rst(rst), .opcode(opcode), .cf_i(cf_i), .dm_addr(dm_addr),
    .dm_we(dm_we), .dm_wdata(dm_wdata), .pc_o(pc_o), .ma_o(ma_o), .lx_o(lx_o),
    .ip_o(ip_o), .lf_o(lf_o), .rs_o(rs_o), .ss_o(ss_o)
);

// File: tb/fstk_mem_slice_test.sv
module fstk_mem_slice_test;
    import fstk_pkg::*;

    localparam logic [PCW-1:0] T_POLL = 15'h0010;
    localparam logic [PCW-1:0] T_NEXT = 15'h0020;
    localparam logic [PCW-1:0] T_FULL = 15'h0030;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] opcode = '0, ax_i = '0, bx_i = '0, dx_i = '0;
    logic cf_i = 1'b0;
    logic [15:0] dm_rdata, dm_addr, dm_wdata, ma_o, lx_o, ip_o;
    logic dm_we, dm_re;
    logic [14:0] pc_o;
    logic [4:0] lf_o, rs_o, ss_o;

    logic [15:0] mem [0:255];
    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    fstk_mem_slice #(.POLL_VEC(T_POLL), .NEXT_VEC(T_NEXT), .FULL_VEC(T_FULL)) uut (
        .clk(clk), .rst(rst), .opcode(opcode), .ax_i(ax_i), .bx_i(bx_i), .dx_i(dx_i),
        .cf_i(cf_i), .dm_rdata(dm_rdata), .dm_addr(dm_addr), .dm_we(dm_we),
        .dm_wdata(dm_wdata), .dm_re(dm_re), .pc_o(pc_o), .ma_o(ma_o), .lx_o(lx_o),
        .ip_o(ip_o), .lf_o(lf_o), .rs_o(rs_o), .ss_o(ss_o)
    );

    assign dm_rdata = mem[dm_addr[7:0]];
    always @(posedge clk) if (dm_we) mem[dm_addr[7:0]] <= dm_wdata;

    typedef struct {
        logic [14:0] pc;
        logic [15:0] ma, lx, ip;
        logic [4:0]  lf, rs, ss;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    exp_t m;   // model state

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // driver: applies one opcode, checks the memory side, queues the expected state
    task automatic step(input mop_e op, input logic [15:0] ax, input logic [15:0] bx,
                        input logic [15:0] dx, input logic cf, input string tag);
        exp_t e;
        logic [15:0] rd;
        logic we_x;
        logic [15:0] wd_x;
        @(negedge clk);
        opcode = {op, 11'h5A5};
        ax_i = ax; bx_i = bx; dx_i = dx; cf_i = cf;
        #1;
        rd = mem[m.ma[7:0]];
        we_x = 1'b1;
        case (op)
            OP_ST_IP, OP_ENTER: wd_x = m.ip;
            OP_ST_AX: wd_x = ax;
            OP_ST_BX: wd_x = bx;
            OP_ST_LX: wd_x = m.lx;
            default: begin we_x = 1'b0; wd_x = '0; end
        endcase
        chk(tag, "dm_addr", dm_addr, m.ma);
        chk(tag, "dm_we", {15'd0, dm_we}, {15'd0, we_x});
        if (we_x) chk(tag, "dm_wdata", dm_wdata, wd_x);
        e = m;
        e.tag = tag;
        e.pc = m.pc + 15'd1;
        case (op)
            OP_LX_AX:    e.lx = ax;
            OP_LX_ONES:  e.lx = 16'hFFFF;
            OP_LD_LX:    e.lx = rd;
            OP_LD_IP:    e.ip = rd;
            OP_LD_LF:    e.lf = rd[4:0];
            OP_LF_GETRS: e.lf = m.rs;
            OP_RS_GETLF: e.rs = m.lf;
            OP_RS_ADD:   e.rs = m.rs + ax[4:0];
            OP_MA_IP:    e.ma = m.ip;
            OP_IP_CADD:  if (cf) e.ip = m.ip + m.lx;
            OP_IP_INC:   e.ip = m.ip + 16'd1;
            OP_POLL:     e.pc = T_POLL;
            OP_NEXT:     begin e.ip = m.ip + 16'd1; e.ma = m.ip + 16'd1; e.pc = T_NEXT; end
            OP_TRAP:     if (cf) e.pc = T_FULL;
            OP_PJMP:     if (m.lx[15]) e.pc = m.lx[14:0];
            OP_ENTER:    begin e.ip = m.lx; e.ma = m.lx; e.pc = T_NEXT; end
            OP_MA_AX:    e.ma = ax;
            OP_MA_BX:    e.ma = bx;
            OP_MA_DX:    e.ma = dx;
            OP_MA_FRAME: e.ma = {11'h007, m.lf};
            OP_MA_LOCAL: e.ma = {11'h007, m.lf} + ax;
            OP_MA_S0:    e.ma = {11'h006, m.ss};
            OP_MA_S1:    e.ma = {11'h006, 5'(m.ss + 5'd1)};
            OP_RPUSH:    begin e.rs = m.rs - 5'd1; e.ma = {11'h007, 5'(m.rs - 5'd1)}; end
            OP_RPULL:    begin e.ma = {11'h007, m.rs}; e.rs = m.rs + 5'd1; end
            OP_SPUSH:    begin e.ss = m.ss - 5'd1; e.ma = {11'h006, 5'(m.ss - 5'd1)}; end
            OP_SPULL:    begin e.ma = {11'h006, m.ss}; e.ss = m.ss + 5'd1; end
            default:     ;
        endcase
        sbq.push_back(e);
        m = e;
    endtask

    // monitor: compares the registered state one edge after each opcode
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                e = sbq.pop_front();
                chk(e.tag, "pc", {1'b0, pc_o}, {1'b0, e.pc});
                chk(e.tag, "ma", ma_o, e.ma);
                chk(e.tag, "lx", lx_o, e.lx);
                chk(e.tag, "ip", ip_o, e.ip);
                chk(e.tag, "lf", {11'd0, lf_o}, {11'd0, e.lf});
                chk(e.tag, "rs", {11'd0, rs_o}, {11'd0, e.rs});
                chk(e.tag, "ss", {11'd0, ss_o}, {11'd0, e.ss});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 3 + 16'h0100);
        m = '{pc: 15'd0, ma: 16'd0, lx: 16'd0, ip: 16'd0, lf: 5'd0, rs: 5'd0, ss: 5'd0, tag: "R2"};
        opcode = 16'hF800;   // would be a data pull if reset were ignored
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2: values held during reset
        chk("R2", "dm_we in reset", {15'd0, dm_we}, 16'd0);
        chk("R2", "pc in reset", {1'b0, pc_o}, 16'd0);
        chk("R2", "rs in reset", {11'd0, rs_o}, 16'd0);
        chk("R2", "ss in reset", {11'd0, ss_o}, 16'd0);
        opcode = 16'h0000;
        rst = 1'b0;
        @(posedge clk); #1;
        // R2: first cycle after reset
        chk("R2", "ma", ma_o, 16'd0);
        chk("R2", "lx", lx_o, 16'd0);
        chk("R2", "ip", ip_o, 16'd0);
        chk("R2", "lf", {11'd0, lf_o}, 16'd0);
        m.pc = pc_o;  // pc after the reset-release edge, checked below
        chk("R2", "pc after release", {1'b0, pc_o}, 16'd1);
        m.pc = 15'd1;

        step(OP_NOP,     16'h1111, 16'h2222, 16'h3333, 1'b1, "R1");
        // R4 data stack with wrap below zero, store and read back
        step(OP_SPUSH,   16'h0, 16'h0, 16'h0, 1'b0, "R4");
        step(OP_ST_BX,   16'h0, 16'h1234, 16'h0, 1'b0, "R10");
        step(OP_MA_S0,   16'h0, 16'h0, 16'h0, 1'b0, "R4");
        step(OP_MA_S1,   16'h0, 16'h0, 16'h0, 1'b0, "R4");
        step(OP_SPULL,   16'h0, 16'h0, 16'h0, 1'b0, "R13");
        step(OP_LD_LX,   16'h0, 16'h0, 16'h0, 1'b0, "R10");
        // R6 primitive jump, taken and not taken
        step(OP_LX_AX,   16'h8123, 16'h0, 16'h0, 1'b0, "R8");
        step(OP_PJMP,    16'h0, 16'h0, 16'h0, 1'b0, "R6");
        step(OP_LX_AX,   16'h0042, 16'h0, 16'h0, 1'b0, "R8");
        step(OP_PJMP,    16'h0, 16'h0, 16'h0, 1'b0, "R6");
        step(OP_LX_ONES, 16'h0, 16'h0, 16'h0, 1'b0, "R8");
        step(OP_PJMP,    16'h0, 16'h0, 16'h0, 1'b0, "R6");
        // R3 and R9 return stack and frame
        step(OP_RPUSH,   16'h0, 16'h0, 16'h0, 1'b0, "R3");
        step(OP_ST_AX,   16'hABCD, 16'h0, 16'h0, 1'b0, "R10");
        step(OP_LF_GETRS,16'h0, 16'h0, 16'h0, 1'b0, "R9");
        step(OP_MA_FRAME,16'h0, 16'h0, 16'h0, 1'b0, "R9");
        step(OP_LD_LX,   16'h0, 16'h0, 16'h0, 1'b0, "R10");
        step(OP_MA_LOCAL,16'h0002, 16'h0, 16'h0, 1'b0, "R9");
        step(OP_RS_ADD,  16'hFFE3, 16'h0, 16'h0, 1'b0, "R9");
        step(OP_RPULL,   16'h0, 16'h0, 16'h0, 1'b0, "R3");
        step(OP_RS_GETLF,16'h0, 16'h0, 16'h0, 1'b0, "R9");
        step(OP_RPULL,   16'h0, 16'h0, 16'h0, 1'b0, "R3");
        // R7 enter, R5 next, R8 IP ops
        step(OP_IP_INC,  16'h0, 16'h0, 16'h0, 1'b0, "R8");
        step(OP_MA_DX,   16'h0, 16'h0, 16'h0030, 1'b0, "R12");
        step(OP_LX_AX,   16'h0105, 16'h0, 16'h0, 1'b0, "R8");
        step(OP_ENTER,   16'h0, 16'h0, 16'h0, 1'b0, "R7");
        step(OP_NEXT,    16'h0, 16'h0, 16'h0, 1'b0, "R5");
        step(OP_MA_IP,   16'h0, 16'h0, 16'h0, 1'b0, "R12");
        step(OP_LX_ONES, 16'h0, 16'h0, 16'h0, 1'b0, "R8");
        step(OP_IP_CADD, 16'h0, 16'h0, 16'h0, 1'b1, "R8");
        step(OP_IP_CADD, 16'h0, 16'h0, 16'h0, 1'b0, "R8");
        step(OP_ST_IP,   16'h0, 16'h0, 16'h0, 1'b0, "R10");
        step(OP_ST_LX,   16'h0, 16'h0, 16'h0, 1'b0, "R10");
        step(OP_MA_BX,   16'h0, 16'h00FF, 16'h0, 1'b0, "R12");
        step(OP_LD_IP,   16'h0, 16'h0, 16'h0, 1'b0, "R10");
        step(OP_MA_AX,   16'h0030, 16'h0, 16'h0, 1'b0, "R12");
        step(OP_LD_LF,   16'h0, 16'h0, 16'h0, 1'b0, "R10");
        // R11 vectors
        step(OP_POLL,    16'h0, 16'h0, 16'h0, 1'b1, "R11");
        step(OP_TRAP,    16'h0, 16'h0, 16'h0, 1'b0, "R11");
        step(OP_TRAP,    16'h0, 16'h0, 16'h0, 1'b1, "R11");
        step(OP_NOP,     16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0, "R1");
        repeat (3) @(posedge clk);
        #1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule